// File: doc/BRIEF.md
# Direct-Mapped Read-Only Line Cache

This block is a small read-only cache, of the kind that holds instructions, placed between a requester and a pipelined Wishbone master port. The requester offers a 32-bit word address. On a hit the block answers one clock later with the stored word, a valid pulse and the address the word belongs to. On a miss it fetches the whole containing line with a burst of pipelined single-word reads, stores it, records its tag, sets the line's valid bit and then answers.

Addresses count 32-bit words, so byte offsets never appear. The low `LS` bits of an address pick a word inside a line. The low `CS` bits pick a word inside the whole cache. The bits from `LS` upward form the stored tag. Each returning bus word is placed by taking the next address to be issued and subtracting the number of reads still waiting for an acknowledge. A flush input drops every line at once. A bus error aborts the fill and is reported to the requester.

Top module: `dm_line_cache`

## Requirements
- R1: A request whose line is valid and whose address bits `[AW-1:LS]` equal the stored tag is answered by `rsp_valid` in the clock after acceptance. The answer carries the stored word, `rsp_addr` equal to the request and `rsp_err` low, and the bus stays idle.
- R2: A miss raises `wb_cyc` and `wb_stb` and issues exactly 2^LS reads at consecutive addresses. The first read is at the request address with its low `LS` bits cleared.
- R3: While `wb_stb` and `wb_stall` are both high, `wb_addr` holds its value. `wb_stb` is low once all 2^LS reads are accepted. `wb_cyc` falls in the clock after the final acknowledge.
- R4: Each acknowledged word is written at the data entry given by the low `CS` bits of (next request address minus outstanding reads). This stays correct under stalls and delayed acknowledges, so every word of the filled line later hits with its own data.
- R5: When the last word of a fill has been acknowledged, the tag is stored, the line becomes valid and the requested word is returned with `rsp_err` low.
- R6: `req_ready` is low from the acceptance of a miss until its response. A request held during that time is neither answered nor fetched.
- R7: `wb_err` during a fill ends the bus cycle and gives one `rsp_valid` with `rsp_err` high. The line was invalidated when the fill began and stays invalid, so a later request to it misses again.
- R8: `flush` clears every valid bit in one clock, so every later request misses until its line is refilled. A request accepted in the same clock as `flush` is treated as a miss.
- R9: After reset, all lines are invalid, `wb_cyc`, `wb_stb` and `rsp_valid` are low, and `req_ready` is high.
- R10: A miss to a line index that holds a different tag replaces that line. A later request with the old tag misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Requested word address |
| req_ready | output | 1 | Block can take a request |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | Response ended in a bus error |
| rsp_addr | output | AW | Word address of the response |
| rsp_data | output | 32 | Returned word |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Read request strobe |
| wb_addr | output | AW | Bus word address |
| wb_stall | input | 1 | Slave cannot take the request |
| wb_ack | input | 1 | Read data valid |
| wb_err | input | 1 | Bus error |
| wb_rdata | input | 32 | Read data |

## Verification
The bench builds the block with `AW=10`, `CS=4` and `LS=2`. This gives four lines of four words each, so index conflicts between different tags can be reached with small addresses such as 0x05 and 0x45. The bus model can stall every few clocks and acknowledge only on alternate clocks, which keeps several reads outstanding. This exercises the subtraction that places each returning word. An error can be injected at a chosen position in the burst.

// File: rtl/dmlc_pkg.sv
package dmlc_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'd0,
        CTL_FILL = 2'd1,
        CTL_RESP = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/dmlc_store.sv
module dmlc_store #(
    parameter int AW = 24,
    parameter int CS = 8,
    parameter int LS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [AW-1:0]                 lk_addr,
    output logic                          lk_hit,
    output logic [dmlc_pkg::WORD_W-1:0]   rd_word,
    input  logic                          inv_en,
    input  logic [CS-LS-1:0]              inv_line,
    input  logic                          set_en,
    input  logic [CS-LS-1:0]              set_line,
    input  logic [AW-LS-1:0]              set_tag,
    input  logic                          wr_en,
    input  logic [CS-1:0]                 wr_idx,
    input  logic [dmlc_pkg::WORD_W-1:0]   wr_word
);
    localparam int NWORDS = 1 << CS;
    localparam int NLINES = 1 << (CS - LS);
    localparam int TW     = AW - LS;
    localparam int DW     = dmlc_pkg::WORD_W;

    typedef struct packed {
        logic [NWORDS-1:0][DW-1:0] data;
        logic [NLINES-1:0][TW-1:0] tag;
        logic [NLINES-1:0]         valid;
    } store_t;

    store_t st_d, st_q;

    logic [CS-LS-1:0] lk_line;
    assign lk_line = lk_addr[CS-1:LS];
    assign lk_hit  = st_q.valid[lk_line] && (st_q.tag[lk_line] == lk_addr[AW-1:LS]);
    assign rd_word = st_q.data[lk_addr[CS-1:0]];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data[wr_idx] = wr_word;
        end
        if (inv_en) begin
            st_d.valid[inv_line] = 1'b0;
        end
        if (set_en) begin
            st_d.tag[set_line]   = set_tag;
            st_d.valid[set_line] = 1'b1;
        end
        if (flush) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a flush leaves no line valid
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0));

    // R5: completing a fill without flush leaves that line valid
    assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !flush) |=> st_q.valid[$past(set_line)]);
endmodule

// File: rtl/dmlc_filler.sv
module dmlc_filler #(
    parameter int AW = 24,
    parameter int CS = 8,
    parameter int LS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic          wb_stall,
    input  logic          wb_ack,
    input  logic          wb_err,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic [AW-1:0] wb_addr,
    output logic          wr_en,
    output logic [CS-1:0] wr_idx,
    output logic          done,
    output logic          fail
);
    localparam int LINE_WORDS = 1 << LS;
    localparam int CNT_W      = LS + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_WORDS - 1);

    typedef struct packed {
        logic             cyc;
        logic             stb;
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] issued;
        logic [CNT_W-1:0] pend;
        logic [CNT_W-1:0] got;
    } fill_t;

    fill_t fl_d, fl_q;
    logic  accepted;

    assign accepted = fl_q.stb && !wb_stall;
    assign wb_cyc   = fl_q.cyc;
    assign wb_stb   = fl_q.stb;
    assign wb_addr  = fl_q.addr;
    assign wr_idx   = fl_q.addr[CS-1:0] - CS'(fl_q.pend);

    always_comb begin
        fl_d  = fl_q;
        wr_en = 1'b0;
        done  = 1'b0;
        fail  = 1'b0;
        if (start) begin
            fl_d.cyc    = 1'b1;
            fl_d.stb    = 1'b1;
            fl_d.addr   = base_addr;
            fl_d.issued = '0;
            fl_d.pend   = '0;
            fl_d.got    = '0;
        end else if (fl_q.cyc) begin
            if (wb_err) begin
                fl_d.cyc  = 1'b0;
                fl_d.stb  = 1'b0;
                fl_d.pend = '0;
                fail      = 1'b1;
            end else begin
                if (accepted) begin
                    fl_d.addr   = fl_q.addr + AW'(1);
                    fl_d.issued = fl_q.issued + CNT_W'(1);
                    if (fl_q.issued == LAST) begin
                        fl_d.stb = 1'b0;
                    end
                end
                if (wb_ack) begin
                    wr_en    = 1'b1;
                    fl_d.got = fl_q.got + CNT_W'(1);
                    if (fl_q.got == LAST) begin
                        fl_d.cyc = 1'b0;
                        fl_d.stb = 1'b0;
                        done     = 1'b1;
                    end
                end
                fl_d.pend = fl_q.pend + CNT_W'(accepted) - CNT_W'(wb_ack);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    // R3: strobe only inside a cycle
    assert_stb_in_cyc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);

    // R3: a stalled request keeps its address
    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_stall && !wb_err) |=> $stable(wb_addr));

    // R4: never more reads outstanding than a line holds
    assert_pend_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.pend <= CNT_W'(LINE_WORDS));

    // R2: a completed fill issued exactly one line of reads
    assert_full_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fl_q.issued == CNT_W'(LINE_WORDS)));
endmodule

// File: rtl/dm_line_cache.sv
module dm_line_cache #(
    parameter int AW = 24,
    parameter int CS = 8,
    parameter int LS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [AW-1:0] rsp_addr,
    output logic [31:0]   rsp_data,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic [AW-1:0] wb_addr,
    input  logic          wb_stall,
    input  logic          wb_ack,
    input  logic          wb_err,
    input  logic [31:0]   wb_rdata
);
    import dmlc_pkg::*;

    typedef struct packed {
        ctl_state_e       state;
        logic [AW-1:0]    addr;
        logic             rsp_valid;
        logic             rsp_err;
        logic [AW-1:0]    rsp_addr;
        logic [WORD_W-1:0] rsp_data;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic              lk_hit;
    logic [WORD_W-1:0] rd_word;
    logic [AW-1:0]     lk_addr;
    logic              fill_start;
    logic              fill_done;
    logic              fill_fail;
    logic              wr_en;
    logic [CS-1:0]     wr_idx;
    logic [AW-1:0]     line_base;

    assign lk_addr   = (ct_q.state == CTL_IDLE) ? req_addr : ct_q.addr;
    assign line_base = {req_addr[AW-1:LS], {LS{1'b0}}};
    assign req_ready = (ct_q.state == CTL_IDLE);
    assign rsp_valid = ct_q.rsp_valid;
    assign rsp_err   = ct_q.rsp_err;
    assign rsp_addr  = ct_q.rsp_addr;
    assign rsp_data  = ct_q.rsp_data;

    always_comb begin
        ct_d           = ct_q;
        ct_d.rsp_valid = 1'b0;
        ct_d.rsp_err   = 1'b0;
        fill_start     = 1'b0;
        case (ct_q.state)
            CTL_IDLE: begin
                if (req_valid) begin
                    if (lk_hit && !flush) begin
                        ct_d.rsp_valid = 1'b1;
                        ct_d.rsp_addr  = req_addr;
                        ct_d.rsp_data  = rd_word;
                    end else begin
                        ct_d.addr  = req_addr;
                        ct_d.state = CTL_FILL;
                        fill_start = 1'b1;
                    end
                end
            end
            CTL_FILL: begin
                if (fill_fail) begin
                    ct_d.rsp_valid = 1'b1;
                    ct_d.rsp_err   = 1'b1;
                    ct_d.rsp_addr  = ct_q.addr;
                    ct_d.rsp_data  = '0;
                    ct_d.state     = CTL_IDLE;
                end else if (fill_done) begin
                    ct_d.state = CTL_RESP;
                end
            end
            CTL_RESP: begin
                ct_d.rsp_valid = 1'b1;
                ct_d.rsp_addr  = ct_q.addr;
                ct_d.rsp_data  = rd_word;
                ct_d.state     = CTL_IDLE;
            end
            default: ct_d.state = CTL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_q       <= '0;
            ct_q.state <= CTL_IDLE;
        end else begin
            ct_q <= ct_d;
        end
    end

    dmlc_store #(.AW(AW), .CS(CS), .LS(LS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_addr  (lk_addr),
        .lk_hit   (lk_hit),
        .rd_word  (rd_word),
        .inv_en   (fill_start),
        .inv_line (req_addr[CS-1:LS]),
        .set_en   (fill_done),
        .set_line (ct_q.addr[CS-1:LS]),
        .set_tag  (ct_q.addr[AW-1:LS]),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wb_rdata)
    );

    dmlc_filler #(.AW(AW), .CS(CS), .LS(LS)) u_filler (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fill_start),
        .base_addr (line_base),
        .wb_stall  (wb_stall),
        .wb_ack    (wb_ack),
        .wb_err    (wb_err),
        .wb_cyc    (wb_cyc),
        .wb_stb    (wb_stb),
        .wb_addr   (wb_addr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .done      (fill_done),
        .fail      (fill_fail)
    );

    // R6: no request is taken while the bus cycle runs
    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc |-> !req_ready);

    // R7: the error flag only rides on a response
    assert_err_on_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R1: a response never overlaps an active bus cycle start
    assert_hit_no_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && lk_hit && !flush) |=> (rsp_valid && !wb_cyc));
endmodule

// File: tb/dm_line_cache_bench.sv
`timescale 1ns/1ps
module dm_line_cache_bench;
    localparam int AW = 10;
    localparam int CS = 4;
    localparam int LS = 2;
    localparam int LW = 1 << LS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic          rsp_err;
    logic [AW-1:0] rsp_addr;
    logic [31:0]   rsp_data;
    logic          wb_cyc;
    logic          wb_stb;
    logic [AW-1:0] wb_addr;
    logic          wb_stall = 1'b0;
    logic          wb_ack = 1'b0;
    logic          wb_err = 1'b0;
    logic [31:0]   wb_rdata = '0;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dm_line_cache #(.AW(AW), .CS(CS), .LS(LS)) u_dm_line_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_addr(wb_addr),
        .wb_stall(wb_stall), .wb_ack(wb_ack), .wb_err(wb_err), .wb_rdata(wb_rdata)
    );

    function automatic logic [31:0] word_of(input logic [AW-1:0] a);
        return 32'hC0DE_0000 ^ (32'(a) * 32'h0004_0001);
    endfunction

    // bus slave model
    bit            stall_mode = 0;
    bit            slow_ack = 0;
    int            err_idx = -1;
    int            fill_cnt = 0;
    int            iss_cnt = 0;
    int            ack_cnt = 0;
    bit            seq_ok = 1;
    bit            hold_ok = 1;
    bit            late = 0;
    bit            prev_cyc = 0;
    bit            hold_pend = 0;
    logic [AW-1:0] held_a = '0;
    logic [AW-1:0] first_a = '0;
    logic [AW-1:0] last_a = '0;
    logic [AW-1:0] aq[$];
    int            tick = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            wb_ack <= 1'b0;
            wb_err <= 1'b0;
            wb_stall <= 1'b0;
            aq.delete();
        end else begin
            tick++;
            if (wb_cyc && iss_cnt >= LW && ack_cnt >= LW && !wb_ack && !wb_err && err_idx < 0)
                late = 1;
            if (hold_pend && wb_stb && wb_addr != held_a) hold_ok = 0;
            hold_pend = wb_cyc && wb_stb && wb_stall;
            held_a = wb_addr;
            if (wb_cyc && !prev_cyc) begin
                fill_cnt++;
                iss_cnt = 0;
                ack_cnt = 0;
                seq_ok = 1;
            end
            prev_cyc = wb_cyc;
            if (wb_cyc && wb_stb && !wb_stall) begin
                if (iss_cnt == 0) first_a = wb_addr;
                else if (wb_addr != last_a + AW'(1)) seq_ok = 0;
                last_a = wb_addr;
                iss_cnt++;
                aq.push_back(wb_addr);
            end
            wb_ack <= 1'b0;
            wb_err <= 1'b0;
            if (wb_cyc && aq.size() > 0 && (!slow_ack || tick[0])) begin
                logic [AW-1:0] a;
                a = aq.pop_front();
                if (ack_cnt == err_idx) wb_err <= 1'b1;
                else begin
                    wb_ack <= 1'b1;
                    wb_rdata <= word_of(a);
                end
                ack_cnt++;
            end
            if (!wb_cyc) aq.delete();
            wb_stall <= stall_mode && (tick % 3 != 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [AW-1:0] a, input bit fl, output logic [31:0] d,
                          output bit e, output logic [AW-1:0] ra, output int lat, output int fills);
        int f0;
        f0 = fill_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        flush = fl;
        @(negedge clk);
        req_valid = 1'b0;
        flush = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
        e = rsp_err;
        ra = rsp_addr;
        fills = fill_cnt - f0;
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
        check(!rsp_valid && !wb_cyc && !wb_stb, "R9", "idle outputs after reset",
              {29'b0, rsp_valid, wb_cyc, wb_stb}, 0);
    endtask

    task automatic t_cold_miss();
        logic [31:0] d; bit e; logic [AW-1:0] ra; int lat, f;
        do_req(10'h005, 0, d, e, ra, lat, f);
        check(f == 1, "R2", "one fill on miss", 32'(f), 1);
        check(first_a == 10'h004, "R2", "line-aligned start", 32'(first_a), 32'h4);
        check(iss_cnt == LW && seq_ok, "R2", "reads issued", 32'(iss_cnt), LW);
        check(ack_cnt == LW && !late, "R3", "cyc falls after last ack", 32'(late), 0);
        check(d == word_of(10'h005) && !e && ra == 10'h005, "R5", "miss answer data",
              d, word_of(10'h005));
    endtask

    task automatic t_hits();
        for (int i = 4; i < 8; i++) begin
            logic [31:0] d; bit e; logic [AW-1:0] ra; int lat, f;
            if (i == 5) continue;
            do_req(AW'(i), 0, d, e, ra, lat, f);
            check(lat == 1 && f == 0, "R1", "hit latency and no fill", 32'(lat), 1);
            check(d == word_of(AW'(i)) && ra == AW'(i) && !e, "R1", "hit data",
                  d, word_of(AW'(i)));
        end
    endtask

    task automatic t_stall_fill();
        logic [31:0] d; bit e; logic [AW-1:0] ra; int lat, f;
        stall_mode = 1;
        slow_ack = 1;
        do_req(10'h02B, 0, d, e, ra, lat, f);
        stall_mode = 0;
        slow_ack = 0;
        check(hold_ok, "R3", "address held under stall", 32'(hold_ok), 1);
        check(iss_cnt == LW && seq_ok && first_a == 10'h028, "R2", "stalled burst",
              32'(iss_cnt), LW);
        check(d == word_of(10'h02B) && !e, "R4", "stalled fill answer", d, word_of(10'h02B));
        for (int i = 8'h28; i < 8'h2B; i++) begin
            logic [31:0] d2; bit e2; logic [AW-1:0] ra2; int lat2, f2;
            do_req(AW'(i), 0, d2, e2, ra2, lat2, f2);
            check(f2 == 0 && d2 == word_of(AW'(i)), "R4", "word placement after stalls",
                  d2, word_of(AW'(i)));
        end
    endtask

    task automatic t_conflict();
        logic [31:0] d; bit e; logic [AW-1:0] ra; int lat, f;
        do_req(10'h045, 0, d, e, ra, lat, f);
        check(f == 1 && d == word_of(10'h045), "R10", "conflicting tag fetched", d, word_of(10'h045));
        do_req(10'h005, 0, d, e, ra, lat, f);
        check(f == 1, "R10", "evicted line misses", 32'(f), 1);
        check(d == word_of(10'h005), "R10", "refetched data", d, word_of(10'h005));
    endtask

    task automatic t_error();
        logic [31:0] d; bit e; logic [AW-1:0] ra; int lat, f;
        err_idx = 2;
        do_req(10'h013, 0, d, e, ra, lat, f);
        err_idx = -1;
        check(e && f == 1 && ra == 10'h013, "R7", "error reported", 32'(e), 1);
        repeat (3) @(negedge clk);
        check(!wb_cyc, "R7", "cycle abandoned", 32'(wb_cyc), 0);
        do_req(10'h013, 0, d, e, ra, lat, f);
        check(f == 1 && !e, "R7", "errored line still invalid", 32'(f), 1);
        check(d == word_of(10'h013), "R7", "retry data", d, word_of(10'h013));
    endtask

    task automatic t_busy();
        int f0, pulses, lat;
        bit ready_ok;
        logic [31:0] d;
        logic [AW-1:0] ra;
        f0 = fill_cnt;
        pulses = 0;
        ready_ok = 1;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = 10'h031;
        @(negedge clk);
        req_addr = 10'h006;
        lat = 1;
        while (!rsp_valid && lat < 400) begin
            if (req_ready) ready_ok = 0;
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        d = rsp_data;
        ra = rsp_addr;
        repeat (4) begin
            @(negedge clk);
            if (rsp_valid) pulses++;
        end
        check(ready_ok, "R6", "ready low during fill", 32'(ready_ok), 1);
        check(ra == 10'h031 && d == word_of(10'h031), "R6", "answer is first request",
              32'(ra), 32'h31);
        check(pulses == 0 && fill_cnt - f0 == 1, "R6", "held request ignored", 32'(pulses), 0);
    endtask

    task automatic t_flush();
        logic [31:0] d; bit e; logic [AW-1:0] ra; int lat, f;
        do_req(10'h02A, 1, d, e, ra, lat, f);
        check(f == 1 && d == word_of(10'h02A), "R8", "request with flush misses", 32'(f), 1);
        do_req(10'h006, 0, d, e, ra, lat, f);
        check(f == 1 && d == word_of(10'h006), "R8", "other line flushed", 32'(f), 1);
        do_req(10'h007, 0, d, e, ra, lat, f);
        check(f == 0 && lat == 1 && d == word_of(10'h007), "R1", "hit after refill", 32'(lat), 1);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold_miss();
        t_hits();
        t_stall_fill();
        t_conflict();
        t_error();
        t_busy();
        t_flush();
        report();
        $finish;
    end
endmodule